// File: doc/BRIEF.md
# Flash Status Byte Readout

This block is the status-read path of a NAND-type flash device. The host writes a one-byte command into the command latch. When that command is the status-read code 70h, the read path switches to status mode. From then on, any read cycle with both chip enable and read enable low drives an 8-bit status byte onto the I/O bus.

The status byte is assembled live from the operation state:
- Write-protect level.
- External ready/busy.
- Pass/fail result of the most recent program or erase.
- In cache-programming mode, two extra fields: the previous operation's result and the true internal busy state.

Because the byte is formed combinationally from these inputs, it tracks state changes while the strobes stay low. The host does not need to toggle them. Status mode persists until any other command is latched, for example 00h, which returns the path to array reads.

Top module: `fsr_status_port`

## Requirements
- R1: After reset the path is not in status mode, `io_oe` is 0, `io_out` is 00h and both stored results are pass (0).
- R2: Latching command 70h (`cmd_we` high at a rising clock edge) enters status mode from the next cycle onward.
- R3: In status mode the byte is driven (`io_oe`=1) only while `ce_n` and `re_n` are both low. Whenever `io_oe` is 0, `io_out` is 00h.
- R4: Bit 0 is the result of the latest completed operation (0 pass, 1 fail). It takes `op_fail` at the rising edge where `op_done` is high.
- R5: Bit 6 is ready/busy: 1 when `rdy_live` is 1 (ready), 0 when busy.
- R6: Bit 7 is write-protect: it equals `wp_n_lvl` (0 protected, 1 not protected).
- R7: With `cache_mode`=1, bit 1 is the previous operation's result and bit 5 is the true internal ready state (1 when `core_busy` is 0). With `cache_mode`=0, bits 5..1 are 0. Bits 4..2 are always 0.
- R8: On each completed operation, the previous-result bit takes the old value of bit 0 in the same edge in which bit 0 takes the new result.
- R9: Latching any command other than 70h leaves status mode from the next cycle; `io_oe` stays 0 until 70h is latched again.
- R10: With strobes held low in status mode, `io_out` follows changes of `rdy_live`, `wp_n_lvl`, `core_busy` and `cache_mode` in the same cycle, without the strobes being toggled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command latch strobe, one cycle |
| cmd_byte | input | 8 | Command code |
| ce_n | input | 1 | Chip enable, active low |
| re_n | input | 1 | Read enable, active low |
| rdy_live | input | 1 | External ready (1) / busy (0) |
| wp_n_lvl | input | 1 | Write-protect level, 0 protected |
| cache_mode | input | 1 | Cache-programming mode active |
| core_busy | input | 1 | True internal busy flag |
| op_done | input | 1 | Operation-complete pulse |
| op_fail | input | 1 | Result with `op_done`, 1 fail |
| io_out | output | 8 | I/O bus data |
| io_oe | output | 1 | I/O bus output enable |

## Verification
The bench builds the block with its default 8-bit command width and status code 70h. That configuration is small enough to cover the whole input space by sweeping:
- Every one of the eight three-operation pass/fail histories.
- For each history, all sixteen combinations of ready, write-protect, cache mode and internal busy, with the strobes held low.

Every bit of the status byte is therefore compared in every mode. The two-stage history is compared against an arithmetic model. Strobe combinations and command exit and re-entry are exercised separately.

// File: rtl/fsr_status_port.sv
module fsr_status_port #(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] STATUS_CMD = 8'h70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             ce_n,
  input  logic             re_n,
  input  logic             rdy_live,
  input  logic             wp_n_lvl,
  input  logic             cache_mode,
  input  logic             core_busy,
  input  logic             op_done,
  input  logic             op_fail,
  output logic [7:0]       io_out,
  output logic             io_oe
);

  logic stat_mode;
  logic res_cur, res_prev;
  logic [7:0] stat_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_mode <= 1'b0;
    end else if (cmd_we) begin
      stat_mode <= (cmd_byte == STATUS_CMD);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_cur  <= 1'b0;
      res_prev <= 1'b0;
    end else if (op_done) begin
      res_prev <= res_cur;
      res_cur  <= op_fail;
    end
  end

  assign stat_byte = {wp_n_lvl,
                      rdy_live,
                      cache_mode & ~core_busy,
                      3'b000,
                      cache_mode & res_prev,
                      res_cur};

  assign io_oe  = stat_mode & ~ce_n & ~re_n;
  assign io_out = io_oe ? stat_byte : 8'h00;

endmodule

// File: rtl/fsr_status_chk.sv
module fsr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [7:0] cmd_byte,
  input logic       ce_n,
  input logic       re_n,
  input logic       wp_n_lvl,
  input logic       rdy_live,
  input logic       cache_mode,
  input logic       op_done,
  input logic       op_fail,
  input logic [7:0] io_out,
  input logic       io_oe
);

  a_r3_oe_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (!ce_n && !re_n));

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !io_oe |-> (io_out == 8'h00));

  a_r4_latest_result: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_done) && io_oe) |-> (io_out[0] == $past(op_fail)));

  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (io_out[4:2] == 3'b000));

  a_r8_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_done) && $past(io_oe) && $past(cache_mode) && io_oe && cache_mode)
      |-> (io_out[1] == $past(io_out[0])));

  a_r9_exit_on_other: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_we) && ($past(cmd_byte) != 8'h70)) |-> !io_oe);

  a_r6_wp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (io_out[7] == wp_n_lvl));

  a_r5_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (io_out[6] == rdy_live));

endmodule

bind fsr_status_port fsr_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
  .ce_n(ce_n), .re_n(re_n), .wp_n_lvl(wp_n_lvl), .rdy_live(rdy_live),
  .cache_mode(cache_mode), .op_done(op_done), .op_fail(op_fail),
  .io_out(io_out), .io_oe(io_oe)
);

// File: tb/fsr_status_port_bench.sv
module fsr_status_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic ce_n = 1'b1, re_n = 1'b1;
  logic rdy_live = 1'b1, wp_n_lvl = 1'b1, cache_mode = 1'b0, core_busy = 1'b0;
  logic op_done = 1'b0, op_fail = 1'b0;
  logic [7:0] io_out;
  logic io_oe;

  int n_cmp = 0, n_bad = 0;
  bit m_cur = 1'b0, m_prev = 1'b0;

  always #4 clk = ~clk;

  fsr_status_port u_fsr_status_port (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .ce_n(ce_n), .re_n(re_n), .rdy_live(rdy_live), .wp_n_lvl(wp_n_lvl),
    .cache_mode(cache_mode), .core_busy(core_busy), .op_done(op_done),
    .op_fail(op_fail), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_byte = c;
    @(negedge clk); cmd_we = 1'b0; cmd_byte = 8'h00;
    #1;
  endtask

  task automatic finish_op(input bit f);
    @(negedge clk); op_done = 1'b1; op_fail = f;
    @(negedge clk); op_done = 1'b0; op_fail = 1'b0;
    m_prev = m_cur; m_cur = f;
    #1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ce_n = 1'b0; re_n = 1'b0;
    @(negedge clk); #1;
    chk("R1 oe after reset", io_oe, 0);
    chk("R1 bus after reset", io_out, 8'h00);

    send_cmd(8'h70);
    chk("R2 status mode entered", io_oe, 1);
    // R1: stored results reset to pass; R6 wp=1, R5 ready=1, non-cache
    chk("R1 reset status byte", io_out, 8'hC0);

    for (int s = 0; s < 4; s++) begin
      ce_n = s[0]; re_n = s[1]; #1;
      chk("R3 strobe oe", io_oe, (s == 0) ? 1 : 0);
      chk("R3 strobe bus", io_out, (s == 0) ? 8'hC0 : 8'h00);
    end
    ce_n = 1'b0; re_n = 1'b0; #1;

    send_cmd(8'h00);
    chk("R9 exit on 00h oe", io_oe, 0);
    chk("R9 exit on 00h bus", io_out, 0);
    finish_op(1'b1);
    chk("R9 stays out after op", io_oe, 0);
    send_cmd(8'h71);
    chk("R9 other code not status", io_oe, 0);
    send_cmd(8'h70);
    chk("R2 re-entry", io_oe, 1);
    chk("R4 result while out of mode", io_out[0], 1);

    for (int h = 0; h < 8; h++) begin
      for (int k = 0; k < 3; k++) begin
        finish_op(h[k]);
        chk("R4 bit0 after op", io_out[0], m_cur);
        cache_mode = 1'b1; #1;
        chk("R8 history shift", io_out[1], m_prev);
        cache_mode = 1'b0; #1;
      end
      for (int c = 0; c < 16; c++) begin
        rdy_live = c[0]; wp_n_lvl = c[1]; cache_mode = c[2]; core_busy = c[3];
        #1;
        chk("R10 live oe", io_oe, 1);
        chk("R6 wp bit", io_out[7], c[1]);
        chk("R5 ready bit", io_out[6], c[0]);
        chk("R7 bit5", io_out[5], c[2] & ~c[3]);
        chk("R7 bits4..2", io_out[4:2], 0);
        chk("R7 bit1", io_out[1], c[2] & m_prev);
        chk("R4 bit0", io_out[0], m_cur);
        @(negedge clk); #1;
        chk("R10 held after edge", io_out[7:6], {c[1], c[0]});
      end
    end
    summary();
  end
endmodule